// File: doc/BRIEF.md
# Prioritised 64-source interrupt controller

This block collects 64 level-sensitive interrupt requests. It keeps a pending word, a mask word and a software force word, each 64 bits wide, and an 8-bit priority level for every source. On every clock it picks the strongest active source. It then presents that source's level, clipped to three bits, and an interrupt vector to the processor. A vector of 24 with level 0 means nothing is requesting service.

Software uses a plain 32-bit register port on an 8-bit byte address. A write is taken in the cycle that `reg_we` is high. A read is combinational from `reg_addr`. The port has no valid/ready handshake and never stalls: every access completes in its own cycle, so there is no back-pressure to manage. Two byte-wide shortcut registers set or clear a single mask bit, or all mask bits at once. The software acknowledge location returns the vector currently presented.

Top module: `prio_intc`

## Requirements
- R1: Source n is active exactly when (pending[n] or force[n]) is 1, its level is non-zero, and mask[n] is 0.
- R2: The active source with the largest stored 8-bit level wins. When two active sources have the same level, the one with the larger index wins.
- R3: While a source wins, `cpu_vector` is its index plus 64. While no source is active, `cpu_vector` is 24 and `cpu_level` is 0.
- R4: `cpu_level` is the winner's stored level when that level is 7 or less, and 7 otherwise.
- R5: `cpu_level` and `cpu_vector` are registered. They reflect the register and pending state that holds after the previous clock edge, so a change shows one edge after it is stored.
- R6: A write to byte address 0x40+n (n = 0..63) stores `reg_wdata[7:0]` as the level of source n. A read there returns that level in bits 7:0, with zeros above it.
- R7: Reads at 0x00/0x04 return pending bits 63:32/31:0, at 0x08/0x0C mask bits 63:32/31:0, and at 0x10/0x14 force bits 63:32/31:0. Writes to 0x08/0x0C and 0x10/0x14 replace the matching mask or force half.
- R8: Each pending bit takes the value of its `irq_req` bit at every clock edge. Writes to 0x00 and 0x04 change nothing.
- R9: A write to 0x1C sets the mask bit picked by `reg_wdata[5:0]`, or sets all 64 mask bits when `reg_wdata[6]` is 1. A write to 0x1D clears in the same way.
- R10: A read at 0xE0 returns the current `cpu_vector` in bits 7:0. A read at 0xE1 to 0xE7, or at any other address not listed in R6 or R7, returns 0.
- R11: A write to any address not listed in R6, R7, R8 or R9 changes no state.
- R12: While `rst_n` is low, every mask bit is 1, pending, force and all levels are 0, `cpu_vector` is 24 and `cpu_level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | 64 | Level-sensitive request lines, bit n is source n |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| cpu_level | output | 3 | Clipped priority level of the winner |
| cpu_vector | output | 8 | Interrupt vector of the winner, or 24 when idle |

## Verification
The embedded properties check these on every cycle:
- the selected source is really active, and no winner is reported without one (R1);
- the idle encoding and the clipping of the level output (R3, R4);
- pending tracking the request lines one edge later (R8);
- level stores and the all-bits mask shortcuts (R6, R9).

Some behaviour needs the bench's reference model and directed scenarios. Such behaviour includes:
- the winner rule across many competing sources, including ties on level (R2);
- the exact vector value (R3);
- that ignored and unknown writes leave every readable word untouched (R8, R11);
- the single-bit mask shortcuts (R9);
- the readback map, swept over all 256 addresses (R6, R7, R10).

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int unsigned SRC_N  = 64;
  localparam int unsigned IDX_W  = $clog2(SRC_N);
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned VEC_W  = 8;

  localparam logic [ADDR_W-1:0] A_PEND_HI = 8'h00;
  localparam logic [ADDR_W-1:0] A_PEND_LO = 8'h04;
  localparam logic [ADDR_W-1:0] A_MASK_HI = 8'h08;
  localparam logic [ADDR_W-1:0] A_MASK_LO = 8'h0C;
  localparam logic [ADDR_W-1:0] A_FRC_HI  = 8'h10;
  localparam logic [ADDR_W-1:0] A_FRC_LO  = 8'h14;
  localparam logic [ADDR_W-1:0] A_MSET    = 8'h1C;
  localparam logic [ADDR_W-1:0] A_MCLR    = 8'h1D;
  localparam logic [ADDR_W-1:0] A_ACK     = 8'hE0;
  localparam logic [1:0]        A_LVL_TOP = 2'b01;

  localparam logic [VEC_W-1:0]  IDLE_VEC  = 8'd24;
  localparam logic [VEC_W-1:0]  VEC_BASE  = 8'd64;
  localparam int unsigned       ALL_BIT   = 6;
endpackage

// File: rtl/prio_intc_regs.sv
module prio_intc_regs
  import prio_intc_pkg::*;
#(
  parameter int unsigned LVL_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SRC_N-1:0]              irq_req,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [VEC_W-1:0]              vec_now,
  output logic [DATA_W-1:0]             rdata,
  output logic [SRC_N-1:0]              pend,
  output logic [SRC_N-1:0]              mask,
  output logic [SRC_N-1:0]              frc,
  output logic [SRC_N-1:0][LVL_W-1:0]   lvl
);
  localparam int unsigned HALF = SRC_N / 2;

  logic lvl_hit;
  assign lvl_hit = (addr[ADDR_W-1:ADDR_W-2] == A_LVL_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      mask <= '1;
      frc  <= '0;
      lvl  <= '0;
    end else begin
      pend <= irq_req;
      if (we) begin
        if (lvl_hit) begin
          lvl[addr[IDX_W-1:0]] <= wdata[LVL_W-1:0];
        end else begin
          case (addr)
            A_MASK_HI: mask[SRC_N-1:HALF] <= wdata[HALF-1:0];
            A_MASK_LO: mask[HALF-1:0]     <= wdata[HALF-1:0];
            A_FRC_HI:  frc[SRC_N-1:HALF]  <= wdata[HALF-1:0];
            A_FRC_LO:  frc[HALF-1:0]      <= wdata[HALF-1:0];
            A_MSET: begin
              if (wdata[ALL_BIT]) mask <= '1;
              else                mask[wdata[IDX_W-1:0]] <= 1'b1;
            end
            A_MCLR: begin
              if (wdata[ALL_BIT]) mask <= '0;
              else                mask[wdata[IDX_W-1:0]] <= 1'b0;
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (lvl_hit) begin
      rdata[LVL_W-1:0] = lvl[addr[IDX_W-1:0]];
    end else begin
      case (addr)
        A_PEND_HI: rdata = pend[SRC_N-1:HALF];
        A_PEND_LO: rdata = pend[HALF-1:0];
        A_MASK_HI: rdata = mask[SRC_N-1:HALF];
        A_MASK_LO: rdata = mask[HALF-1:0];
        A_FRC_HI:  rdata = frc[SRC_N-1:HALF];
        A_FRC_LO:  rdata = frc[HALF-1:0];
        A_ACK:     rdata[VEC_W-1:0] = vec_now;
        default:   rdata = '0;
      endcase
    end
  end

  p_pend_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> pend == $past(irq_req));

  p_mset_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_MSET && wdata[ALL_BIT]) |=> mask == '1);

  p_mclr_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_MCLR && wdata[ALL_BIT]) |=> mask == '0);

  p_lvl_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && lvl_hit) |=>
      lvl[$past(addr[IDX_W-1:0])] == $past(wdata[LVL_W-1:0]));
endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb
  import prio_intc_pkg::*;
#(
  parameter int unsigned LVL_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SRC_N-1:0]              pend,
  input  logic [SRC_N-1:0]              frc,
  input  logic [SRC_N-1:0]              mask,
  input  logic [SRC_N-1:0][LVL_W-1:0]   lvl,
  output logic                          any_act,
  output logic [IDX_W-1:0]              win_idx,
  output logic [LVL_W-1:0]              win_lvl
);
  localparam int unsigned NODES  = 2 * SRC_N - 1;
  localparam int unsigned STAGES = IDX_W;

  logic [SRC_N-1:0]              act;
  logic [NODES-1:0]              na;
  logic [NODES-1:0][LVL_W-1:0]   nl;
  logic [NODES-1:0][IDX_W-1:0]   ni;

  for (genvar i = 0; i < SRC_N; i++) begin : g_leaf
    assign act[i] = (pend[i] | frc[i]) & ~mask[i] & (lvl[i] != '0);
    assign na[i]  = act[i];
    assign nl[i]  = lvl[i];
    assign ni[i]  = IDX_W'(i);
  end

  for (genvar s = 1; s <= STAGES; s++) begin : g_stage
    localparam int unsigned IN_OFS  = 2 * SRC_N - 2 * (SRC_N >> (s - 1));
    localparam int unsigned OUT_OFS = 2 * SRC_N - 2 * (SRC_N >> s);
    for (genvar j = 0; j < (SRC_N >> s); j++) begin : g_node
      localparam int unsigned LO = IN_OFS + 2 * j;
      localparam int unsigned HI = LO + 1;
      logic take_hi;
      assign take_hi        = na[HI] && (!na[LO] || nl[HI] >= nl[LO]);
      assign na[OUT_OFS + j] = na[LO] | na[HI];
      assign nl[OUT_OFS + j] = take_hi ? nl[HI] : nl[LO];
      assign ni[OUT_OFS + j] = take_hi ? ni[HI] : ni[LO];
    end
  end

  assign any_act = na[NODES-1];
  assign win_lvl = nl[NODES-1];
  assign win_idx = ni[NODES-1];

  p_win_is_active_r1: assert property (@(posedge clk) disable iff (!rst_n)
    any_act |-> act[win_idx]);

  p_none_active_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !any_act |-> act == '0);
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int unsigned LVL_W     = 8,
  parameter int unsigned OUT_LVL_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [63:0]        irq_req,
  input  logic               reg_we,
  input  logic [7:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic [2:0]         cpu_level,
  output logic [7:0]         cpu_vector
);
  localparam int unsigned OUT_MAX = (1 << OUT_LVL_W) - 1;

  logic [SRC_N-1:0]             pend, mask, frc;
  logic [SRC_N-1:0][LVL_W-1:0]  lvl_tbl;
  logic                         any_act;
  logic [IDX_W-1:0]             win_idx;
  logic [LVL_W-1:0]             win_lvl;
  logic [OUT_LVL_W-1:0]         lvl_d;
  logic [VEC_W-1:0]             vec_d;

  prio_intc_regs #(.LVL_W(LVL_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_req (irq_req),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .vec_now (cpu_vector),
    .rdata   (reg_rdata),
    .pend    (pend),
    .mask    (mask),
    .frc     (frc),
    .lvl     (lvl_tbl)
  );

  prio_intc_arb #(.LVL_W(LVL_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend    (pend),
    .frc     (frc),
    .mask    (mask),
    .lvl     (lvl_tbl),
    .any_act (any_act),
    .win_idx (win_idx),
    .win_lvl (win_lvl)
  );

  always_comb begin
    if (!any_act) begin
      lvl_d = '0;
      vec_d = IDLE_VEC;
    end else begin
      lvl_d = (win_lvl > LVL_W'(OUT_MAX)) ? OUT_LVL_W'(OUT_MAX)
                                          : win_lvl[OUT_LVL_W-1:0];
      vec_d = VEC_BASE + VEC_W'(win_idx);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_level  <= '0;
      cpu_vector <= IDLE_VEC;
    end else begin
      cpu_level  <= lvl_d;
      cpu_vector <= vec_d;
    end
  end

  p_idle_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !any_act |=> (cpu_vector == IDLE_VEC && cpu_level == '0));

  p_busy_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    any_act |=> cpu_level != '0);

  p_clip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (any_act && win_lvl >= LVL_W'(OUT_MAX)) |=> cpu_level == OUT_LVL_W'(OUT_MAX));

  p_vec_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_vector == IDLE_VEC) || (cpu_vector >= VEC_BASE && cpu_vector < VEC_BASE + 8'd64));
endmodule

// File: tb/prio_intc_test.sv
module prio_intc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_req = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  cpu_level;
  logic [7:0]  cpu_vector;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  bit [63:0] m_pend, m_mask, m_frc;
  bit [7:0]  m_lvl [64];
  int        m_vec;

  always #5 clk = ~clk;

  prio_intc uut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_level(cpu_level), .cpu_vector(cpu_vector)
  );

  // Reference: strongest active source, ties to the larger index (R1, R2, R3, R4)
  function automatic void ref_out(output int lv, output int vec);
    int best_l = 0;
    int best_i = -1;
    for (int i = 0; i < 64; i++) begin
      if ((m_pend[i] || m_frc[i]) && !m_mask[i] && m_lvl[i] != 0 && m_lvl[i] >= best_l) begin
        best_l = m_lvl[i];
        best_i = i;
      end
    end
    if (best_i < 0) begin lv = 0; vec = 24; end
    else begin lv = (best_l > 7) ? 7 : best_l; vec = best_i + 64; end
  endfunction

  function automatic bit [31:0] ref_read(input bit [7:0] a);
    if (a >= 8'h40 && a < 8'h80) return {24'd0, m_lvl[a - 8'h40]};
    case (a)
      8'h00: return m_pend[63:32];
      8'h04: return m_pend[31:0];
      8'h08: return m_mask[63:32];
      8'h0C: return m_mask[31:0];
      8'h10: return m_frc[63:32];
      8'h14: return m_frc[31:0];
      8'hE0: return 32'(m_vec);
      default: return 32'd0;
    endcase
  endfunction

  function automatic string read_tag(input bit [7:0] a);
    if (!rst_n) return "R12";
    if (a >= 8'h40 && a < 8'h80) return "R6";
    if (a <= 8'h14 && a[1:0] == 2'b00 && a != 8'h18) return "R7";
    return "R10";
  endfunction

  task automatic ref_write(input bit [7:0] a, input bit [31:0] d);
    if (a >= 8'h40 && a < 8'h80) begin m_lvl[a - 8'h40] = d[7:0]; return; end
    case (a)
      8'h08: m_mask[63:32] = d;
      8'h0C: m_mask[31:0]  = d;
      8'h10: m_frc[63:32]  = d;
      8'h14: m_frc[31:0]   = d;
      8'h1C: if (d[6]) m_mask = '1; else m_mask[d[5:0]] = 1'b1;
      8'h1D: if (d[6]) m_mask = '0; else m_mask[d[5:0]] = 1'b0;
      default: ; // R8, R11: no state change
    endcase
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One clock: model the edge, then compare at the following negedge (R5)
  task automatic cycle();
    int e_lv, e_vec;
    ref_out(e_lv, e_vec);
    if (!rst_n) begin
      m_pend = '0; m_mask = '1; m_frc = '0;
      for (int i = 0; i < 64; i++) m_lvl[i] = 8'd0;
      e_lv = 0; e_vec = 24;
    end else begin
      if (reg_we) ref_write(reg_addr, reg_wdata);
      m_pend = irq_req;
    end
    m_vec = e_vec;
    @(posedge clk);
    @(negedge clk);
    check(rst_n ? "R4" : "R12", "cpu_level", int'(cpu_level), e_lv);
    check(rst_n ? "R3" : "R12", "cpu_vector", int'(cpu_vector), e_vec);
    check(read_tag(reg_addr), "reg_rdata", int'(reg_rdata), int'(ref_read(reg_addr)));
  endtask

  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    cycle();
    reg_we = 1'b0;
  endtask

  task automatic rd(input bit [7:0] a, input int n);
    reg_addr = a;
    for (int k = 0; k < n; k++) cycle();
  endtask

  initial begin
    #(10 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R12: reset state
    rd(8'h08, 2); rd(8'h0C, 1); rd(8'h4A, 1); rd(8'hE0, 1);
    rst_n = 1'b1;
    rd(8'h0C, 2); rd(8'hE0, 1);

    // R1: masked source stays quiet, unmasking exposes it
    wr(8'h45, 32'd3);
    irq_req[5] = 1'b1;
    rd(8'h00, 2);
    wr(8'h1D, 32'd5);            // R9 single clear
    rd(8'hE0, 2);                // R3: vector 69, R5 latency
    // R2: equal level, larger index wins
    wr(8'h68, 32'd3); wr(8'h1D, 32'd40); irq_req[40] = 1'b1;
    rd(8'hE0, 2);
    wr(8'h4A, 32'd6); wr(8'h1D, 32'd10); irq_req[10] = 1'b1;
    rd(8'hE0, 2);
    // R4: level above 7 clipped, still compared at full width
    wr(8'h42, 32'd200); wr(8'h1D, 32'd2); irq_req[2] = 1'b1;
    wr(8'h63, 32'd199); wr(8'h1D, 32'd35); irq_req[35] = 1'b1;
    rd(8'hE0, 2);
    // R1: zero level disables the source
    wr(8'h42, 32'd0);
    rd(8'h42, 2);
    // R1/R7: force drives a source with no request
    irq_req = '0;
    wr(8'h43, 32'd1); wr(8'h1D, 32'd3); wr(8'h14, 32'h0000_0008);
    rd(8'h14, 2);
    wr(8'h10, 32'h8000_0000); wr(8'h7F, 32'd9); wr(8'h1D, 32'd63);
    rd(8'hE0, 2);
    // R9: all-bits shortcuts and single set
    wr(8'h1C, 32'h40); rd(8'h08, 2);
    wr(8'h1D, 32'h40); rd(8'h0C, 2);
    wr(8'h1C, 32'd63); rd(8'h08, 2);
    // R7: direct mask halves
    wr(8'h08, 32'h0F0F_0000); wr(8'h0C, 32'hFFFF_FFF7); rd(8'h08, 1); rd(8'h0C, 1);
    // R8: pending writes ignored, pending tracks inputs
    irq_req = 64'hDEAD_BEEF_0123_4567;
    wr(8'h00, 32'hFFFF_FFFF); wr(8'h04, 32'h0);
    rd(8'h00, 1); rd(8'h04, 1);
    irq_req = '0;
    rd(8'h04, 2);
    // R11: unknown addresses ignored; R10 reads zero there
    wr(8'h18, 32'hFFFF_FFFF); wr(8'h80, 32'hFF); wr(8'hE0, 32'h12);
    wr(8'hE3, 32'h1); wr(8'hFF, 32'hFFFF_FFFF); wr(8'h1E, 32'h40);
    rd(8'hE5, 1); rd(8'h0C, 1); rd(8'h10, 1); rd(8'h14, 1);

    // Mixed stress: random requests and register traffic (R1, R2, R5)
    for (int n = 0; n < 600; n++) begin
      int sel;
      bit [7:0] a;
      bit [31:0] d;
      irq_req = {$urandom, $urandom};
      sel = $urandom_range(0, 9);
      d = $urandom;
      case (sel)
        0, 1, 2: begin a = 8'h40 + 8'($urandom_range(0, 63)); d = (d[0]) ? 32'(d[4:1]) : 32'(d[15:8]); end
        3: begin a = 8'h1D; d = d & 32'h7F; if (d[6] && d[1]) d[6] = 1'b0; end
        4: begin a = 8'h1C; d = d & 32'h3F; end
        5: a = (d[0]) ? 8'h08 : 8'h0C;
        6: a = (d[0]) ? 8'h10 : 8'h14;
        7: a = 8'h00;
        default: a = 8'($urandom_range(0, 255));
      endcase
      if (sel < 9) wr(a, d); else rd(a, 1);
    end

    // R6, R7, R10: readback sweep of the whole map
    for (int a = 0; a < 256; a++) rd(8'(a), 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule